// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor

This block is a small multi-cycle processor with exactly one instruction. An instruction is three consecutive memory words: the address of the subtrahend, the address of the minuend (which also receives the result), and a branch target. The machine reads both operands and subtracts the first from the second. It writes the difference back over the second operand. If the difference is negative it continues at the target; otherwise it continues at the instruction three words further on.

A fixed sequencer drives a datapath that holds a program counter, a memory address register, an operand register, a memory data register and two flag registers. The subtraction is done by an adder that complements one input and forces a carry-in of one. The block talks to an external word-addressed memory with a one-cycle read latency. Execution starts at address 0 when reset is released. The machine stops for good when an instruction jumps to its own address with a negative result.

Top module: `subneg_machine`

## Requirements
- R1: While reset is held low, `pc_o` is 0, `halted`, `flag_n`, `flag_z` and `mem_wr` are 0.
- R2: For an instruction at address P, the memory accesses occur in this order: read P, read word a (the content of P), read P+1, read word b (the content of P+1), write b, read P+2. There are exactly six accesses.
- R3: The value written to address b is mem[b] minus mem[a], taken modulo 2^32.
- R4: When bit 31 of the difference is 1, the next instruction address is the content of word P+2.
- R5: When bit 31 of the difference is 0, the next instruction address is P+3 modulo 2^ADDR_W, so an instruction at the top of memory continues at address 0.
- R6: `flag_n` equals bit 31 of the last difference, and `flag_z` is 1 exactly when the last difference is 0. Both update on the write edge and hold until the next write.
- R7: One instruction takes 10 clock cycles, with at most one memory access per cycle and one write per instruction, issued in the 8th cycle.
- R8: A taken jump whose target word equals the instruction's own address sets `halted`. From then on there are no memory accesses, `pc_o` holds, and `halted` stays 1 until reset.
- R9: When both operand addresses are the same, the result is 0, `flag_z` is 1, and the jump is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W | Word address of the current access |
| mem_rd | output | 1 | Read request; data returns on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | DATA_W | Difference being stored |
| mem_rdata | input | DATA_W | Read data, registered by the memory |
| pc_o | output | ADDR_W | Address of the current instruction |
| flag_n | output | 1 | Sign of the last difference |
| flag_z | output | 1 | Last difference was zero |
| halted | output | 1 | Machine has stopped |

## Verification
Counted from the first rising edge after reset release, the write of the difference occurs on the 8th edge. The flags become visible right after that edge. `pc_o` takes its new value on the 10th edge, and `halted` rises on that same edge for a self-jump. The bench releases reset on a falling edge and waits whole cycles from there. It samples memory, flags and PC only on falling edges after the 10th rising edge, where every result of the instruction has settled. The access order is logged on each rising edge and compared only after the instruction is complete.

// File: rtl/subneg_pkg.sv
package subneg_pkg;

  typedef enum logic [3:0] {
    ST_FETCH_A = 4'd0,
    ST_LOAD_A  = 4'd1,
    ST_READ_A  = 4'd2,
    ST_FETCH_B = 4'd3,
    ST_LOAD_B  = 4'd4,
    ST_READ_B  = 4'd5,
    ST_GRAB_B  = 4'd6,
    ST_WRITE   = 4'd7,
    ST_FETCH_T = 4'd8,
    ST_BRANCH  = 4'd9,
    ST_HALT    = 4'd10
  } seq_state_t;

  typedef enum logic [1:0] {
    AS_PC0 = 2'd0,
    AS_PC1 = 2'd1,
    AS_PC2 = 2'd2,
    AS_MAR = 2'd3
  } addr_sel_t;

endpackage

// File: rtl/subneg_adder.sv
module subneg_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         neg,
  output logic         zero
);
  logic [W-1:0] b_x;
  logic [W:0]   carry;

  assign b_x      = inv ? ~b : b;
  assign carry[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = a[i] ^ b_x[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b_x[i]) | (carry[i] & (a[i] ^ b_x[i]));
    end
  endgenerate

  assign neg  = sum[W-1];
  assign zero = (sum == '0);

  logic unused_cout;
  assign unused_cout = carry[W];
endmodule

// File: rtl/subneg_ctrl.sv
module subneg_ctrl
  import subneg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      self_jump,
  output addr_sel_t addr_sel,
  output logic      mem_rd,
  output logic      mem_wr,
  output logic      ld_mar,
  output logic      ld_r,
  output logic      ld_mdr,
  output logic      ld_flags,
  output logic      ld_pc,
  output logic      alu_sub,
  output logic      halted
);
  seq_state_t state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_FETCH_A;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH_A: state_d = ST_LOAD_A;
      ST_LOAD_A:  state_d = ST_READ_A;
      ST_READ_A:  state_d = ST_FETCH_B;
      ST_FETCH_B: state_d = ST_LOAD_B;
      ST_LOAD_B:  state_d = ST_READ_B;
      ST_READ_B:  state_d = ST_GRAB_B;
      ST_GRAB_B:  state_d = ST_WRITE;
      ST_WRITE:   state_d = ST_FETCH_T;
      ST_FETCH_T: state_d = ST_BRANCH;
      ST_BRANCH:  state_d = self_jump ? ST_HALT : ST_FETCH_A;
      ST_HALT:    state_d = ST_HALT;
      default:    state_d = ST_FETCH_A;
    endcase
  end

  always_comb begin
    addr_sel = AS_PC0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    ld_mar   = 1'b0;
    ld_r     = 1'b0;
    ld_mdr   = 1'b0;
    ld_flags = 1'b0;
    ld_pc    = 1'b0;
    alu_sub  = 1'b0;
    unique case (state_q)
      ST_FETCH_A: begin addr_sel = AS_PC0; mem_rd = 1'b1; end
      ST_LOAD_A:  ld_mar = 1'b1;
      ST_READ_A:  begin addr_sel = AS_MAR; mem_rd = 1'b1; end
      ST_FETCH_B: begin addr_sel = AS_PC1; mem_rd = 1'b1; ld_r = 1'b1; end
      ST_LOAD_B:  ld_mar = 1'b1;
      ST_READ_B:  begin addr_sel = AS_MAR; mem_rd = 1'b1; end
      ST_GRAB_B:  ld_mdr = 1'b1;
      ST_WRITE:   begin
        addr_sel = AS_MAR; mem_wr = 1'b1; ld_flags = 1'b1; alu_sub = 1'b1;
      end
      ST_FETCH_T: begin addr_sel = AS_PC2; mem_rd = 1'b1; end
      ST_BRANCH:  ld_pc = 1'b1;
      default:    ;
    endcase
  end

  assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/subneg_datapath.sv
module subneg_datapath
  import subneg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  addr_sel_t         addr_sel,
  input  logic              ld_mar,
  input  logic              ld_r,
  input  logic              ld_mdr,
  input  logic              ld_flags,
  input  logic              ld_pc,
  input  logic              alu_sub,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic              flag_n,
  output logic              flag_z,
  output logic              self_jump
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] r_q, mdr_q;
  logic              n_q, z_q;
  logic [ADDR_W-1:0] pc_p1, pc_p2, pc_p3, pc_next;
  logic [DATA_W-1:0] diff;
  logic              diff_neg, diff_zero;
  logic [ADDR_W-1:0] target;

  assign pc_p1  = pc_q + ADDR_W'(1);
  assign pc_p2  = pc_q + ADDR_W'(2);
  assign pc_p3  = pc_q + ADDR_W'(3);
  assign target = mem_rdata[ADDR_W-1:0];

  always_comb begin
    unique case (addr_sel)
      AS_PC0:  mem_addr = pc_q;
      AS_PC1:  mem_addr = pc_p1;
      AS_PC2:  mem_addr = pc_p2;
      default: mem_addr = mar_q;
    endcase
  end

  subneg_adder #(.W(DATA_W)) u_adder (
    .a    (mdr_q),
    .b    (r_q),
    .inv  (alu_sub),
    .cin  (alu_sub),
    .sum  (diff),
    .neg  (diff_neg),
    .zero (diff_zero)
  );

  assign pc_next   = n_q ? target : pc_p3;
  assign self_jump = n_q && (mem_rdata == {{PAD_W{1'b0}}, pc_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      r_q   <= '0;
      mdr_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      if (ld_mar)   mar_q <= target;
      if (ld_r)     r_q   <= mem_rdata;
      if (ld_mdr)   mdr_q <= mem_rdata;
      if (ld_flags) begin
        n_q <= diff_neg;
        z_q <= diff_zero;
      end
      if (ld_pc)    pc_q  <= pc_next;
    end
  end

  assign mem_wdata = diff;
  assign pc_o      = pc_q;
  assign flag_n    = n_q;
  assign flag_z    = z_q;
endmodule

// File: rtl/subneg_machine.sv
module subneg_machine
  import subneg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic              flag_n,
  output logic              flag_z,
  output logic              halted
);
  addr_sel_t addr_sel;
  logic ld_mar, ld_r, ld_mdr, ld_flags, ld_pc, alu_sub, self_jump;

  subneg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .self_jump (self_jump),
    .addr_sel  (addr_sel),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ld_mar    (ld_mar),
    .ld_r      (ld_r),
    .ld_mdr    (ld_mdr),
    .ld_flags  (ld_flags),
    .ld_pc     (ld_pc),
    .alu_sub   (alu_sub),
    .halted    (halted)
  );

  subneg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_sel  (addr_sel),
    .ld_mar    (ld_mar),
    .ld_r      (ld_r),
    .ld_mdr    (ld_mdr),
    .ld_flags  (ld_flags),
    .ld_pc     (ld_pc),
    .alu_sub   (alu_sub),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_o      (pc_o),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .self_jump (self_jump)
  );
endmodule

// File: rtl/subneg_machine_chk.sv
module subneg_machine_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] pc_o,
  input logic              flag_n,
  input logic              flag_z,
  input logic              halted
);
  // R7
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R7
  write_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (flag_n == $past(mem_wdata[DATA_W-1])));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (flag_z == ($past(mem_wdata) == '0)));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_o)));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));
endmodule

bind subneg_machine subneg_machine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_wdata (mem_wdata),
  .pc_o      (pc_o),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .halted    (halted)
);

// File: tb/subneg_machine_bench.sv
module subneg_machine_bench;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] pc_o;
  logic          flag_n, flag_z, halted;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] log_a [16];
  logic          log_w [16];
  int            log_n = 0;
  int            errors = 0;
  int            checks = 0;

  always #5 clk = ~clk;

  subneg_machine #(.DATA_W(DW), .ADDR_W(AW)) u_subneg_machine (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .flag_n(flag_n), .flag_z(flag_z), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (!rst_n) log_n <= 0;
    else if ((mem_rd || mem_wr) && log_n < 16) begin
      log_a[log_n] <= mem_addr;
      log_w[log_n] <= mem_wr;
      log_n <= log_n + 1;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic start_prog();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic release_run(input int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [DW-1:0] vals [8];
    vals[0] = 32'd0;          vals[1] = 32'd1;
    vals[2] = 32'hFFFF_FFFF;  vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000;  vals[5] = 32'd5;
    vals[6] = 32'hFFFF_FFFB;  vals[7] = 32'd123456;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pc", DW'(pc_o), '0);
    check("R1 halted", DW'(halted), '0);
    check("R1 flags", DW'({flag_n, flag_z}), '0);
    check("R1 mem_wr", DW'(mem_wr), '0);

    // R3 R4 R5 R6: sweep of operand pairs, one instruction at 0
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [DW-1:0] d;
        start_prog();
        mem[0] = 32'd10; mem[1] = 32'd11; mem[2] = 32'd40;
        mem[10] = vals[i]; mem[11] = vals[j];
        d = vals[j] - vals[i];
        release_run(10);
        check("R3 difference", mem[11], d);
        check("R4/R5 next pc", DW'(pc_o), d[DW-1] ? 32'd40 : 32'd3);
        check("R6 flag_n", DW'(flag_n), DW'(d[DW-1]));
        check("R6 flag_z", DW'(flag_z), DW'(d == '0));
        if (i == 1 && j == 5) begin
          // R2 R7: access order and single write
          check("R2 access count", DW'(log_n), 32'd6);
          check("R2 read P", DW'({log_w[0], log_a[0]}), 32'd0);
          check("R2 read a", DW'({log_w[1], log_a[1]}), 32'd10);
          check("R2 read P+1", DW'({log_w[2], log_a[2]}), 32'd1);
          check("R2 read b", DW'({log_w[3], log_a[3]}), 32'd11);
          check("R7 write b", DW'({log_w[4], log_a[4]}), DW'({1'b1, 8'd11}));
          check("R2 read P+2", DW'({log_w[5], log_a[5]}), 32'd2);
        end
      end
    end

    // R7: ten cycles per instruction, nothing written early
    start_prog();
    mem[0] = 32'd10; mem[1] = 32'd11; mem[2] = 32'd40;
    mem[10] = 32'd2; mem[11] = 32'd9;
    release_run(7);
    check("R7 no write before 8th cycle", mem[11], 32'd9);
    check("R7 pc held mid-instruction", DW'(pc_o), 32'd0);
    repeat (1) @(negedge clk);
    check("R7 write at 8th cycle", mem[11], 32'd7);
    repeat (1) @(negedge clk);
    check("R7 pc held at 9th cycle", DW'(pc_o), 32'd0);
    repeat (1) @(negedge clk);
    check("R7 pc at 10th cycle", DW'(pc_o), 32'd3);

    // R9: same operand address
    start_prog();
    mem[0] = 32'd12; mem[1] = 32'd12; mem[2] = 32'd40;
    mem[12] = 32'hDEAD_BEEF;
    release_run(10);
    check("R9 result zero", mem[12], '0);
    check("R9 flag_z", DW'(flag_z), 32'd1);
    check("R9 not taken", DW'(pc_o), 32'd3);

    // R5: wrap past top of memory, R4: chained taken jump
    start_prog();
    mem[0] = 32'd10; mem[1] = 32'd11; mem[2] = 32'd253;
    mem[10] = 32'd1; mem[11] = 32'd0;
    mem[253] = 32'd20; mem[254] = 32'd21; mem[255] = 32'd99;
    mem[20] = 32'd3; mem[21] = 32'd8;
    release_run(10);
    check("R4 taken to 253", DW'(pc_o), 32'd253);
    repeat (10) @(negedge clk);
    check("R3 second result", mem[21], 32'd5);
    check("R5 wrap to 0", DW'(pc_o), 32'd0);

    // R8: self jump halts
    start_prog();
    mem[0] = 32'd20; mem[1] = 32'd21; mem[2] = 32'd0;
    mem[20] = 32'd1; mem[21] = 32'd0;
    release_run(9);
    check("R8 not halted before 10th cycle", DW'(halted), 32'd0);
    repeat (1) @(negedge clk);
    check("R8 halted", DW'(halted), 32'd1);
    check("R8 result", mem[21], 32'hFFFF_FFFF);
    repeat (20) @(negedge clk);
    check("R8 halted sticky", DW'(halted), 32'd1);
    check("R8 pc held", DW'(pc_o), 32'd0);
    check("R8 no more accesses", DW'(log_n), 32'd6);
    check("R8 memory untouched", mem[21], 32'hFFFF_FFFF);

    finish_up();
  end
endmodule